// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt flag for each side of a two-port shared memory. The two highest addresses of the space serve as mailboxes. The second-highest address belongs to the left side and the highest address belongs to the right side. When one side writes into its partner's mailbox, the partner's flag is raised. The partner drops its flag by reading its own mailbox.

The block only observes each side's memory strobes and address. It does not store the message: the mailbox words stay ordinary array words that the surrounding memory holds. A design that never uses the flags loses no capacity.

Each side also supplies a write-inhibit status. While that status is active, a write from that side cannot raise the partner's flag. Flags change on the rising clock edge after the qualifying access. They are driven active low at all times.

Top module: `dp_mbx_irq`

## Requirements
- R1: After the asynchronous reset is released, both `l_irq_no` and `r_irq_no` are high (flag clear).
- R2: A right-side write (`r_ce_ni`=0, `r_we_ni`=0, `r_busy_ni`=1) to address 2^ADDR_W-2 (0x3FFE for ADDR_W=14) drives `l_irq_no` low after the next rising edge.
- R3: A left-side write (`l_ce_ni`=0, `l_we_ni`=0, `l_busy_ni`=1) to address 2^ADDR_W-1 (0x3FFF for ADDR_W=14) drives `r_irq_no` low after the next rising edge.
- R4: A left-side access with `l_ce_ni`=0 and `l_oe_ni`=0 at address 2^ADDR_W-2 sets `l_irq_no` high after the next edge, whatever the level of `l_we_ni`.
- R5: A right-side access with `r_ce_ni`=0 and `r_oe_ni`=0 at address 2^ADDR_W-1 sets `r_irq_no` high after the next edge, whatever the level of `r_we_ni`.
- R6: While the writing side's busy input is low, its write to the partner's mailbox leaves the partner's flag unchanged.
- R7: When a raise and a clear of the same flag fall in one cycle, the flag ends up raised.
- R8: An access does not change a flag if its address misses the mailbox, if its chip enable is high, if it is a read with output enable high, or if it is a write into the writer's own mailbox.
- R9: Without a qualifying raise or clear, each flag holds its value from cycle to cycle.
- R10: The mailbox addresses follow from ADDR_W as the two highest addresses. Only the low ADDR_W address bits are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left read/write: 0 write, 1 read |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_busy_ni | input | 1 | Left write inhibit, active low |
| l_addr_i | input | ADDR_W | Left address |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right read/write: 0 write, 1 read |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_busy_ni | input | 1 | Right write inhibit, active low |
| r_addr_i | input | ADDR_W | Right address |
| l_irq_no | output | 1 | Left interrupt flag, active low |
| r_irq_no | output | 1 | Right interrupt flag, active low |

## Verification
The bench builds two copies side by side and drives them with the same strobes. One copy uses the default 14-bit address, and the other uses a 4-bit address that sees only the low nibble. With the narrow copy, a random address lands in a mailbox one time in eight, so raise, clear and collision cycles occur often under random stimulus. The wide copy shows that an address such as 0x1FFE, whose low bits match a mailbox, is ignored when the full width is compared.

// File: rtl/dp_mbx_irq_pkg.sv
package dp_mbx_irq_pkg;
  localparam int unsigned NUM_SIDES = 2;

  typedef enum logic [0:0] {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // per-side access classification
  typedef struct packed {
    logic post;  // write into partner mailbox, not inhibited
    logic take;  // read of own mailbox
  } mbx_evt_t;

  function automatic int unsigned peer_of(input int unsigned side);
    return (side == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/dp_mbx_decode.sv
module dp_mbx_decode
  import dp_mbx_irq_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 14,
  parameter logic [ADDR_W-1:0]      OWN_ADDR  = '1,
  parameter logic [ADDR_W-1:0]      PEER_ADDR = '1
) (
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              busy_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output mbx_evt_t          evt_o
);
  logic sel;
  logic hit_own;
  logic hit_peer;

  assign sel      = ~ce_ni;
  assign hit_own  = (addr_i == OWN_ADDR);
  assign hit_peer = (addr_i == PEER_ADDR);

  always_comb begin
    evt_o      = '0;
    evt_o.post = sel & ~we_ni & busy_ni & hit_peer;
    // read/write level is irrelevant for the clear
    evt_o.take = sel & ~oe_ni & hit_own;
  end
endmodule

// File: rtl/dp_mbx_flag.sv
module dp_mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;
  logic flag_d;

  // raise wins over clear so a message posted during a clear survives
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign irq_no = ~flag_q;
endmodule

// File: rtl/dp_mbx_irq.sv
module dp_mbx_irq
  import dp_mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic              l_busy_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic              r_busy_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_irq_no,
  output logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] MBX_L    = TOP_ADDR - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MBX_R    = TOP_ADDR;

  logic [NUM_SIDES-1:0]             ce_n;
  logic [NUM_SIDES-1:0]             we_n;
  logic [NUM_SIDES-1:0]             oe_n;
  logic [NUM_SIDES-1:0]             busy_n;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr;
  mbx_evt_t [NUM_SIDES-1:0]         evt;
  logic [NUM_SIDES-1:0]             irq_n;

  assign ce_n   = {r_ce_ni,   l_ce_ni};
  assign we_n   = {r_we_ni,   l_we_ni};
  assign oe_n   = {r_oe_ni,   l_oe_ni};
  assign busy_n = {r_busy_ni, l_busy_ni};
  assign addr   = {r_addr_i,  l_addr_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == int'(SIDE_L)) ? MBX_L : MBX_R;
    localparam logic [ADDR_W-1:0] PEER = (s == int'(SIDE_L)) ? MBX_R : MBX_L;
    localparam int unsigned       P    = peer_of(s);

    dp_mbx_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) i_decode (
      .ce_ni  (ce_n[s]),
      .we_ni  (we_n[s]),
      .oe_ni  (oe_n[s]),
      .busy_ni(busy_n[s]),
      .addr_i (addr[s]),
      .evt_o  (evt[s])
    );

    dp_mbx_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt[P].post),
      .clr_i (evt[s].take),
      .irq_no(irq_n[s])
    );
  end

  assign l_irq_no = irq_n[SIDE_L];
  assign r_irq_no = irq_n[SIDE_R];
endmodule

// File: rtl/dp_mbx_irq_chk.sv
module dp_mbx_irq_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_we_ni,
  input logic              l_oe_ni,
  input logic              l_busy_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_ce_ni,
  input logic              r_we_ni,
  input logic              r_oe_ni,
  input logic              r_busy_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_irq_no,
  input logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = HI - ADDR_W'(1);

  logic r_wr_lo, l_wr_hi, l_rd_lo, r_rd_hi;
  assign r_wr_lo = !r_ce_ni && !r_we_ni && (r_addr_i == LO);
  assign l_wr_hi = !l_ce_ni && !l_we_ni && (l_addr_i == HI);
  assign l_rd_lo = !l_ce_ni && !l_oe_ni && (l_addr_i == LO);
  assign r_rd_hi = !r_ce_ni && !r_oe_ni && (r_addr_i == HI);

  assert_raise_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr_lo && r_busy_ni) |=> !l_irq_no);
  assert_raise_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr_hi && l_busy_ni) |=> !r_irq_no);
  assert_clear_left_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_lo && !(r_wr_lo && r_busy_ni)) |=> l_irq_no);
  assert_clear_right_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rd_hi && !(l_wr_hi && l_busy_ni)) |=> r_irq_no);
  assert_inhibit_left_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_irq_no && !r_busy_ni) |=> l_irq_no);
  assert_inhibit_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_irq_no && !l_busy_ni) |=> r_irq_no);
  assert_raise_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_lo && r_wr_lo && r_busy_ni) |=> !l_irq_no);
  assert_no_stray_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_irq_no && !r_wr_lo) |=> l_irq_no);
  assert_hold_left_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_irq_no && !l_rd_lo) |=> !l_irq_no);
  assert_hold_right_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_irq_no && !r_rd_hi) |=> !r_irq_no);
endmodule

bind dp_mbx_irq dp_mbx_irq_chk #(.ADDR_W(ADDR_W)) i_dp_mbx_irq_chk (.*);

// File: tb/test_dp_mbx_irq.sv
module test_dp_mbx_irq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  W_WIDE     = 14;
  localparam int  W_NARROW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_ce_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
  logic [13:0] l_addr = '0, r_addr = '0;
  logic wl_irq_n, wr_irq_n, nl_irq_n, nr_irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // expected flags (1 = raised): wide and narrow copies
  logic exp_wl = 0, exp_wr = 0, exp_nl = 0, exp_nr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_mbx_irq #(.ADDR_W(W_WIDE)) i_dp_mbx_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce_n), .l_we_ni(l_we_n), .l_oe_ni(l_oe_n), .l_busy_ni(l_busy_n), .l_addr_i(l_addr),
    .r_ce_ni(r_ce_n), .r_we_ni(r_we_n), .r_oe_ni(r_oe_n), .r_busy_ni(r_busy_n), .r_addr_i(r_addr),
    .l_irq_no(wl_irq_n), .r_irq_no(wr_irq_n)
  );

  dp_mbx_irq #(.ADDR_W(W_NARROW)) i_dp_mbx_irq_narrow (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce_n), .l_we_ni(l_we_n), .l_oe_ni(l_oe_n), .l_busy_ni(l_busy_n), .l_addr_i(l_addr[3:0]),
    .r_ce_ni(r_ce_n), .r_we_ni(r_we_n), .r_oe_ni(r_oe_n), .r_busy_ni(r_busy_n), .r_addr_i(r_addr[3:0]),
    .l_irq_no(nl_irq_n), .r_irq_no(nr_irq_n)
  );

  // mailbox match: off=1 second-highest, off=0 highest, over w low bits
  function automatic logic mbx_hit(input logic [13:0] a, input int w, input int off);
    logic [13:0] m;
    m = 14'((1 << w) - 1);
    return (a & m) == (m - 14'(off));
  endfunction

  function automatic logic next_flag(input logic f, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : f);
  endfunction

  function automatic logic raise_l(input int w);
    return !r_ce_n && !r_we_n && r_busy_n && mbx_hit(r_addr, w, 1);
  endfunction
  function automatic logic raise_r(input int w);
    return !l_ce_n && !l_we_n && l_busy_n && mbx_hit(l_addr, w, 0);
  endfunction
  function automatic logic drop_l(input int w);
    return !l_ce_n && !l_oe_n && mbx_hit(l_addr, w, 1);
  endfunction
  function automatic logic drop_r(input int w);
    return !r_ce_n && !r_oe_n && mbx_hit(r_addr, w, 0);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "wide l_irq_no",   wl_irq_n, ~exp_wl);
    check(req, "wide r_irq_no",   wr_irq_n, ~exp_wr);
    check(req, "narrow l_irq_no", nl_irq_n, ~exp_nl);
    check(req, "narrow r_irq_no", nr_irq_n, ~exp_nr);
  endtask

  // inputs are set at a falling edge; one rising edge; check at next falling edge
  task automatic step(input string req);
    logic wl, wr, nl, nr;
    wl = next_flag(exp_wl, raise_l(W_WIDE),   drop_l(W_WIDE));
    wr = next_flag(exp_wr, raise_r(W_WIDE),   drop_r(W_WIDE));
    nl = next_flag(exp_nl, raise_l(W_NARROW), drop_l(W_NARROW));
    nr = next_flag(exp_nr, raise_r(W_NARROW), drop_r(W_NARROW));
    @(posedge clk);
    exp_wl = wl; exp_wr = wr; exp_nl = nl; exp_nr = nr;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic idle();
    l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0;
    r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0;
  endtask

  function automatic logic [13:0] pick_addr();
    case ($urandom % 4)
      0:       return 14'h3FFE;
      1:       return 14'h3FFF;
      default: return 14'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    step("R1");

    // R2: right posts into left mailbox
    idle(); r_ce_n = 0; r_we_n = 0; r_addr = 14'h3FFE;
    step("R2");
    idle();
    step("R9");
    // R4: left reads its mailbox
    idle(); l_ce_n = 0; l_oe_n = 0; l_addr = 14'h3FFE;
    step("R4");
    // R3: left posts into right mailbox
    idle(); l_ce_n = 0; l_we_n = 0; l_addr = 14'h3FFF;
    step("R3");
    // R5: right clears with read/write low
    idle(); r_ce_n = 0; r_we_n = 0; r_oe_n = 0; r_addr = 14'h3FFF;
    step("R5");
    // R6: inhibited write does not raise
    idle(); r_ce_n = 0; r_we_n = 0; r_busy_n = 0; r_addr = 14'h3FFE;
    step("R6");
    idle(); l_ce_n = 0; l_we_n = 0; l_busy_n = 0; l_addr = 14'h3FFF;
    step("R6");
    // R7: raise and clear of the right flag together
    idle(); l_ce_n = 0; l_we_n = 0; l_addr = 14'h3FFF;
    r_ce_n = 0; r_oe_n = 0; r_addr = 14'h3FFF;
    step("R7");
    // R8: read without output enable does not clear
    idle(); r_ce_n = 0; r_addr = 14'h3FFF;
    step("R8");
    // R8: deselected write does not raise
    idle(); r_ce_n = 1; r_we_n = 0; r_addr = 14'h3FFE;
    step("R8");
    // R8: write to own mailbox does not raise
    idle(); l_ce_n = 0; l_we_n = 0; l_addr = 14'h3FFE;
    step("R8");
    // R10: low bits match; wide copy ignores, narrow copy raises
    idle(); r_ce_n = 0; r_we_n = 0; r_addr = 14'h1FFE;
    step("R10");
    idle(); l_ce_n = 0; l_oe_n = 0; l_addr = 14'h2FFE;
    step("R10");

    for (int i = 0; i < 3000; i++) begin
      l_ce_n = 1'($urandom % 4 == 0); l_we_n = 1'($urandom); l_oe_n = 1'($urandom);
      l_busy_n = 1'($urandom % 5 != 0); l_addr = pick_addr();
      r_ce_n = 1'($urandom % 4 == 0); r_we_n = 1'($urandom); r_oe_n = 1'($urandom);
      r_busy_n = 1'($urandom % 5 != 0); r_addr = pick_addr();
      step("R9");
    end

    // R1: reset in mid-run clears raised flags
    idle(); l_ce_n = 0; l_we_n = 0; l_addr = 14'h3FFF;
    r_ce_n = 0; r_we_n = 0; r_addr = 14'h3FFE;
    step("R2");
    idle();
    rst_n = 1'b0;
    exp_wl = 0; exp_wr = 0; exp_nl = 0; exp_nr = 0;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule